// File: doc/BRIEF.md
# Serial Register Access Slave

This block sits behind a four-wire serial port (chip select, serial clock, serial data in, serial data out) and turns each frame into byte-wide transactions on a plain internal register bus. A frame opens with a 16-bit instruction word. The word carries a direction flag and a 15-bit register address. Data bytes follow, one register per byte. While chip select stays low, the engine keeps streaming. After every byte it steps the address down by one, so a host can fetch a wide value stored at descending addresses in a single frame.

The serial pins are oversampled by the system clock. Chip select, serial clock and serial data pass through identical synchronizer chains, and an edge detector finds the rising and falling edges of the serial clock. The internal side provides an address, write data, a one-cycle write strobe, a one-cycle read strobe and a combinational read-data return. The read data must be valid in the same cycle as the read strobe. The serial clock half period must be at least SYNC_STAGES + 3 system clock cycles.

Top module: `spi_regbus_slave`

## Requirements
- R1: After reset, spi_miso is 0 and neither bus_wr nor bus_rd is asserted.
- R2: The first 16 bits of a frame are sampled on rising serial clock edges, MSB first. Bit 15 set selects a read and bit 15 clear selects a write. Bits 14..0 are the start address.
- R3: In a write frame, every 8 data bits (MSB first) produce one bus_wr pulse carrying the byte on bus_wdata and the current address on bus_addr.
- R4: While chip select stays low, each later byte targets the previous byte's address minus one.
- R5: Decrementing from address 0x0000 gives 0x7FFF, for both reads and writes.
- R6: In a read frame, bus_rd is pulsed for the start address once the instruction completes. The returned byte appears on spi_miso MSB first: the first bit after the falling edge that ends the instruction, and the next bit after each later falling edge.
- R7: In a read frame, bus_rd is pulsed for the next lower address after each byte completes. Streaming four bytes from 0x0203 takes 48 serial clocks and returns the data of 0x0203, 0x0202, 0x0201 and 0x0200 in that order.
- R8: A rising chip select discards a partially received byte without a write. The next frame starts again with a full instruction.
- R9: spi_miso is 0 during the instruction phase, throughout write frames and while chip select is high.
- R10: If chip select rises in the same sampled cycle as the eighth rising clock edge of a byte, that byte is dropped and no write is issued.
- R11: bus_wr and bus_rd are single-cycle pulses and are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_addr | output | ADDR_W (15) | Register address of the current strobe |
| bus_wdata | output | DATA_W (8) | Write data, valid with bus_wr |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | DATA_W (8) | Read data, valid in the bus_rd cycle |

## Verification
The completion of a data byte and a rising chip select can reach the engine in the same system clock cycle. This happens because both pins travel through synchronizers of equal depth. The bench provokes the collision by moving the serial clock high and releasing chip select at the same instant on the last bit of a write byte. The result is judged by the absence of any write strobe and by a clean following frame. The bench also runs a normal release that respects the hold time; the written byte must land there, which separates the two outcomes.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int RB_ADDR_W = 15;
    localparam int RB_DATA_W = 8;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic csn;
        logic sck;
        logic mosi;
    } pin_t;

    localparam pin_t PIN_IDLE = '{csn: 1'b1, sck: 1'b0, mosi: 1'b0};

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync
    import spi_rb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  pin_t raw,
    output pin_t synced,
    output logic sck_rise,
    output logic sck_fall
);

    pin_t stage_q [STAGES];
    logic sck_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= PIN_IDLE;
                else     stage_q[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= PIN_IDLE;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign synced = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= synced.sck;
    end

    assign sck_rise = synced.sck & ~sck_prev;
    assign sck_fall = ~synced.sck & sck_prev;

endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = RB_ADDR_W,
    parameter int DATA_W = RB_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn,
    input  logic              mosi,
    input  logic              sck_rise,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              rd_active
);

    localparam int INSTR_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(INSTR_W);
    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(DATA_W - 1);

    phase_e              phase;
    logic [CNT_W-1:0]    bit_cnt;
    logic [INSTR_W-1:0]  shreg;
    logic                is_read;
    logic [ADDR_W-1:0]   cur_addr;

    logic [ADDR_W-1:0]   instr_addr;
    logic [DATA_W-1:0]   rx_byte;
    logic [ADDR_W-1:0]   dec_addr;

    // values as they stand once the current bit is shifted in
    assign instr_addr = {shreg[ADDR_W-2:0], mosi};
    assign rx_byte    = {shreg[DATA_W-2:0], mosi};
    assign dec_addr   = cur_addr - ADDR_W'(1);
    assign rd_active  = (phase == PH_DATA) && is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_INSTR;
            bit_cnt   <= '0;
            shreg     <= '0;
            is_read   <= 1'b0;
            cur_addr  <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            if (csn) begin
                // deselect wins over any bit arriving in the same cycle
                phase   <= PH_INSTR;
                bit_cnt <= '0;
                is_read <= 1'b0;
            end else if (sck_rise) begin
                shreg <= {shreg[INSTR_W-2:0], mosi};
                if (phase == PH_INSTR) begin
                    if (bit_cnt == INSTR_LAST) begin
                        phase    <= PH_DATA;
                        bit_cnt  <= '0;
                        is_read  <= shreg[INSTR_W-2];
                        cur_addr <= instr_addr;
                        if (shreg[INSTR_W-2]) begin
                            bus_rd   <= 1'b1;
                            bus_addr <= instr_addr;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end else begin
                    if (bit_cnt == BYTE_LAST) begin
                        bit_cnt  <= '0;
                        cur_addr <= dec_addr;
                        if (is_read) begin
                            bus_rd   <= 1'b1;
                            bus_addr <= dec_addr;
                        end else begin
                            bus_wr    <= 1'b1;
                            bus_addr  <= cur_addr;
                            bus_wdata <= rx_byte;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn,
    input  logic              sck_fall,
    input  logic              active,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso
);

    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || csn) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (sck_fall) begin
            if (active) begin
                miso  <= tx_sh[DATA_W-1];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end else begin
                miso  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W      = RB_ADDR_W,
    parameter int DATA_W      = RB_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);

    pin_t raw_pins;
    pin_t s_pins;
    logic sck_rise;
    logic sck_fall;
    logic rd_active;
    logic csn_s;

    assign raw_pins = '{csn: spi_csn, sck: spi_sck, mosi: spi_mosi};
    assign csn_s    = s_pins.csn;

    spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw_pins),
        .synced   (s_pins),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_rb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .csn       (csn_s),
        .mosi      (s_pins.mosi),
        .sck_rise  (sck_rise),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .rd_active (rd_active)
    );

    spi_rb_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .csn       (csn_s),
        .sck_fall  (sck_fall),
        .active    (rd_active),
        .load      (bus_rd),
        .load_data (bus_rdata),
        .miso      (spi_miso)
    );

endmodule

// File: rtl/spi_regbus_chk.sv
module spi_regbus_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              csn_s,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              spi_miso
);

    logic [ADDR_W-1:0] last_wr_addr;
    logic              wr_seen;

    always_ff @(posedge clk) begin
        if (rst || csn_s) begin
            wr_seen      <= 1'b0;
            last_wr_addr <= '0;
        end else if (bus_wr) begin
            wr_seen      <= 1'b1;
            last_wr_addr <= bus_addr;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(bus_wr && bus_rd)); // R11
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst) bus_wr |=> !bus_wr); // R11
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst) bus_rd |=> !bus_rd); // R11
    AST_ADDR_DECR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && wr_seen) |-> (bus_addr == last_wr_addr - ADDR_W'(1))); // R4
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (!bus_wr && !bus_rd)); // R8
    AST_DESEL_MISO: assert property (@(posedge clk) disable iff (rst) csn_s |=> !spi_miso); // R9

endmodule

bind spi_regbus_slave spi_regbus_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .csn_s    (csn_s),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .spi_miso (spi_miso)
);

// File: tb/tb_spi_regbus_slave.sv
module tb_spi_regbus_slave;

    localparam int HALF = 8;
    localparam int NVEC = 6;
    // [55] read flag, [54:40] address, [39:32] byte count, [31:0] bytes MSB first
    localparam logic [55:0] VEC [NVEC] = '{
        {1'b0, 15'h1234, 8'd1, 32'hC300_0000},
        {1'b0, 15'h0203, 8'd4, 32'h1122_3344},
        {1'b1, 15'h0203, 8'd4, 32'h0000_0000},
        {1'b1, 15'h7FFF, 8'd1, 32'h0000_0000},
        {1'b0, 15'h5555, 8'd2, 32'hA55A_0000},
        {1'b1, 15'h0001, 8'd3, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_csn = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [14:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;

    int total = 0;
    int bad = 0;
    int wr_total = 0;
    int strobe_err = 0;
    logic [14:0] wr_log_a [256];
    logic [7:0]  wr_log_d [256];
    logic        wr_prev = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] model(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    assign bus_rdata = model(bus_addr);

    spi_regbus_slave dut (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        if (bus_wr) begin
            wr_log_a[wr_total[7:0]] <= bus_addr;
            wr_log_d[wr_total[7:0]] <= bus_wdata;
            wr_total <= wr_total + 1;
        end
        if ((bus_wr && bus_rd) || (bus_wr && wr_prev)) strobe_err <= strobe_err + 1;
        wr_prev <= bus_wr;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic rw, input logic [14:0] addr, input int nbits,
                            input logic [31:0] wd, input bit tie_end,
                            output logic [31:0] rd, output bit sdo_bad);
        logic [15:0] ins;
        ins = {rw, addr};
        rd = '0;
        sdo_bad = 1'b0;
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 15; i >= 0; i--) begin
            spi_mosi = ins[i];
            wait_clk(HALF);
            if (spi_miso) sdo_bad = 1'b1;
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        for (int j = 0; j < nbits; j++) begin
            spi_mosi = wd[31-j];
            wait_clk(HALF);
            if (rw) rd[31-j] = spi_miso;
            else if (spi_miso) sdo_bad = 1'b1;
            spi_sck = 1'b1;
            if (tie_end && j == nbits - 1) spi_csn = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        if (!tie_end) begin
            wait_clk(HALF);
            spi_csn = 1'b1;
        end
        wait_clk(3 * HALF);
        if (spi_miso) sdo_bad = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit sdo_bad;
        int base;
        wait_clk(5);
        chk(spi_miso == 1'b0 && bus_wr == 1'b0 && bus_rd == 1'b0, "R1 reset outputs",
            {spi_miso, bus_wr, bus_rd}, 0);
        rst = 1'b0;
        wait_clk(5);
        chk(spi_miso == 1'b0 && bus_wr == 1'b0 && bus_rd == 1'b0, "R1 idle after reset",
            {spi_miso, bus_wr, bus_rd}, 0);

        // table walk: R2 R3 R4 R6 R7 R9, with R5 in the last entry
        for (int v = 0; v < NVEC; v++) begin
            logic        rw;
            logic [14:0] a0;
            int          nb;
            rw = VEC[v][55];
            a0 = VEC[v][54:40];
            nb = int'(VEC[v][39:32]);
            base = wr_total;
            spi_xfer(rw, a0, nb * 8, VEC[v][31:0], 1'b0, rd, sdo_bad);
            chk(!sdo_bad, "R9 miso low in instruction or write frame", sdo_bad, 0);
            if (!rw) begin
                chk(wr_total - base == nb, "R3 write count", wr_total - base, nb);
                for (int i = 0; i < nb; i++) begin
                    logic [14:0] ea;
                    logic [7:0]  ed;
                    ea = a0 - 15'(i);
                    ed = VEC[v][31 - 8*i -: 8];
                    chk(wr_log_a[(base + i) % 256] == ea, "R4 write address",
                        wr_log_a[(base + i) % 256], ea);
                    chk(wr_log_d[(base + i) % 256] == ed, "R3 write data",
                        wr_log_d[(base + i) % 256], ed);
                end
            end else begin
                chk(wr_total == base, "R2 read frame issues no write", wr_total - base, 0);
                for (int i = 0; i < nb; i++) begin
                    logic [7:0] ed;
                    ed = model(a0 - 15'(i));
                    chk(rd[31 - 8*i -: 8] == ed, "R7 R6 read byte", rd[31 - 8*i -: 8], ed);
                end
            end
        end

        // R5: write stream wraps 0x0000 -> 0x7FFF
        base = wr_total;
        spi_xfer(1'b0, 15'h0000, 16, 32'h9966_0000, 1'b0, rd, sdo_bad);
        chk(wr_total - base == 2, "R5 wrap write count", wr_total - base, 2);
        chk(wr_log_a[(base + 1) % 256] == 15'h7FFF, "R5 wrapped address",
            wr_log_a[(base + 1) % 256], 15'h7FFF);
        chk(wr_log_d[(base + 1) % 256] == 8'h66, "R5 wrapped data",
            wr_log_d[(base + 1) % 256], 8'h66);

        // R8: one full byte then 5 bits, then deselect
        base = wr_total;
        spi_xfer(1'b0, 15'h0100, 13, 32'h7EF8_0000, 1'b0, rd, sdo_bad);
        chk(wr_total - base == 1, "R8 partial byte dropped", wr_total - base, 1);
        chk(wr_log_a[base % 256] == 15'h0100 && wr_log_d[base % 256] == 8'h7E,
            "R8 full byte kept", {wr_log_a[base % 256], wr_log_d[base % 256]}, {15'h0100, 8'h7E});
        base = wr_total;
        spi_xfer(1'b0, 15'h0042, 8, 32'h3C00_0000, 1'b0, rd, sdo_bad);
        chk(wr_total - base == 1 && wr_log_a[base % 256] == 15'h0042 && wr_log_d[base % 256] == 8'h3C,
            "R8 realigned next frame", {wr_log_a[base % 256], wr_log_d[base % 256]}, {15'h0042, 8'h3C});

        // R10: chip select rises together with the eighth clock edge
        base = wr_total;
        spi_xfer(1'b0, 15'h0777, 8, 32'hE100_0000, 1'b1, rd, sdo_bad);
        chk(wr_total == base, "R10 coinciding deselect drops byte", wr_total - base, 0);
        base = wr_total;
        spi_xfer(1'b0, 15'h0777, 8, 32'hE100_0000, 1'b0, rd, sdo_bad);
        chk(wr_total - base == 1 && wr_log_d[base % 256] == 8'hE1, "R10 normal release keeps byte",
            wr_total - base, 1);

        chk(strobe_err == 0, "R11 strobes single and exclusive", strobe_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule